// File: doc/BRIEF.md
# Credit-Gated Shared-Pool Output Queue Buffer

This block holds outbound packets for one node of an on-chip packet network. Each packet arrives with a tag that names the neighbor it must go to next. The block stores the payload in one pool of slots that all neighbors share, and it appends the slot to a linked per-neighbor queue. The pool holds `(2*NNEI-1)*NCRED` packets. That size keeps the network free of buffer deadlock when every neighbor holds `NCRED` credits.

A three-state controller serves the queue heads in turn. In `ST_IDLE` it picks the next queue in round-robin order that has a packet and a credit. The transition `idle->req` latches that pick. In `ST_REQ` it asks the channel arbiter for the link. A grant takes it to `ST_SEND` (`req->send`). In `ST_SEND` it presents the packet for exactly one cycle, spends one credit for that neighbor and frees the slot. It then always returns to idle (`send->idle`). The block sends one packet at a time. New packets can still be written and queued while a request is waiting for the arbiter. Each credit counter is refilled when the downstream node reports that it has released a packet.

Top module: `voq_credit_buf`

## Requirements
- R1: After reset, `wr_ready` is 1, `ch_req` is 0, `rd_valid` is 0, and every neighbor holds `NCRED` credits.
- R2: A packet that is accepted with tag h (0..NNEI-1) is later emitted with `rd_hop`=h and unchanged data. Packets with the same tag leave in the order they were accepted.
- R3: A neighbor with no credits is never requested. With no credit returns, at most `NCRED` packets go to one neighbor.
- R4: A pulse on `cred_ret[h]` restores one credit to neighbor h. The count saturates at `NCRED`, and returns made while the count is full have no effect.
- R5: Among queues that have a packet and a credit, the controller picks the first one at or after the neighbor that follows the last one served. The search wraps around, and neighbor 0 is the start after reset.
- R6: `ch_req` and `ch_hop` stay steady until `ch_gnt`. The cycle after the grant, `rd_valid` is high for exactly one cycle.
- R7: The pool has `(2*NNEI-1)*NCRED` slots. `wr_ready` is 0 exactly when all slots are occupied, and a write offered while it is 0 is dropped.
- R8: Writes are accepted in any state, including while a request is waiting for its grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Offer a packet for storage |
| wr_ready | output | 1 | A free slot exists |
| wr_hop | input | HW | Next-hop neighbor index of the offered packet |
| wr_data | input | DW | Packet payload |
| cred_ret | input | NNEI | One-cycle credit return pulse per neighbor |
| ch_req | output | 1 | Channel request toward the arbiter |
| ch_hop | output | HW | Neighbor that the request targets |
| ch_gnt | input | 1 | Arbiter grant |
| rd_valid | output | 1 | Packet leaving this cycle |
| rd_hop | output | HW | Neighbor that receives the packet |
| rd_data | output | DW | Payload that is leaving |

## Verification
The assertions check, on every cycle, the rules that can be written as properties:
- the request stays steady until it is granted;
- a grant is followed by a single-cycle read;
- a shadow count of outstanding packets per neighbor never exceeds the credits, and no neighbor is requested once its credits are spent;
- `wr_ready` matches a shadow occupancy count.

Some behaviours can only be shown by the bench scenarios, which compare against a reference model. These are:
- which queue round-robin picks;
- per-queue FIFO order and data integrity;
- that extra credit returns saturate;
- that a write dropped at a full pool never comes out.

// File: rtl/voq_pkg.sv
package voq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_SEND = 2'd2
    } voq_state_e;
endpackage

// File: rtl/voq_freelist.sv
module voq_freelist #(
    parameter int SLOTS = 10,
    parameter int PW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc,
    output logic [PW-1:0] alloc_idx,
    input  logic          rel_en,
    input  logic [PW-1:0] rel_idx,
    output logic          empty
);
    localparam int CNTW = $clog2(SLOTS + 1);

    logic [PW-1:0]   ring [SLOTS];
    logic [PW-1:0]   rd_p, wr_p;
    logic [CNTW-1:0] cnt;

    function automatic logic [PW-1:0] adv(input logic [PW-1:0] p);
        return (int'(p) == SLOTS - 1) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) ring[i] <= PW'(i);
            rd_p <= '0;
            wr_p <= '0;
            cnt  <= CNTW'(SLOTS);
        end else begin
            if (alloc) rd_p <= adv(rd_p);
            if (rel_en) begin
                ring[wr_p] <= rel_idx;
                wr_p       <= adv(wr_p);
            end
            if (alloc && !rel_en)      cnt <= cnt - 1'b1;
            else if (rel_en && !alloc) cnt <= cnt + 1'b1;
        end
    end

    assign alloc_idx = ring[rd_p];
    assign empty     = (cnt == '0);
endmodule

// File: rtl/voq_credit.sv
module voq_credit #(
    parameter int NCRED = 2,
    parameter int CW    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic consume,
    input  logic give,
    output logic has_credit
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= CW'(NCRED);
        end else begin
            unique case ({consume, give})
                2'b10:   cnt <= cnt - 1'b1;
                2'b01:   if (int'(cnt) != NCRED) cnt <= cnt + 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign has_credit = (cnt != '0);
endmodule

// File: rtl/voq_rr_pick.sv
module voq_rr_pick #(
    parameter int NNEI = 3,
    parameter int HW   = 2
) (
    input  logic [NNEI-1:0] elig,
    input  logic [HW-1:0]   start,
    output logic            any,
    output logic [HW-1:0]   pick
);
    always_comb begin
        any  = 1'b0;
        pick = '0;
        for (int k = NNEI - 1; k >= 0; k--) begin
            int idx;
            idx = int'(start) + k;
            if (idx >= NNEI) idx = idx - NNEI;
            if (elig[idx]) begin
                any  = 1'b1;
                pick = HW'(idx);
            end
        end
    end
endmodule

// File: rtl/voq_credit_buf.sv
module voq_credit_buf
    import voq_pkg::*;
#(
    parameter int NNEI  = 3,
    parameter int NCRED = 2,
    parameter int DW    = 16,
    localparam int HW   = (NNEI > 1) ? $clog2(NNEI) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_valid,
    output logic            wr_ready,
    input  logic [HW-1:0]   wr_hop,
    input  logic [DW-1:0]   wr_data,
    input  logic [NNEI-1:0] cred_ret,
    output logic            ch_req,
    output logic [HW-1:0]   ch_hop,
    input  logic            ch_gnt,
    output logic            rd_valid,
    output logic [HW-1:0]   rd_hop,
    output logic [DW-1:0]   rd_data
);
    localparam int SLOTS = (2 * NNEI - 1) * NCRED;
    localparam int PW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int QW    = $clog2(SLOTS + 1);
    localparam int CW    = $clog2(NCRED + 1);

    voq_state_e state, state_nx;

    logic [DW-1:0] mem   [SLOTS];
    logic [PW-1:0] nxt   [SLOTS];
    logic [PW-1:0] qhead [NNEI];
    logic [PW-1:0] qtail [NNEI];
    logic [QW-1:0] qcnt  [NNEI];

    logic [HW-1:0]   sel, rr, pick;
    logic            any_elig, fl_empty, push, pop;
    logic [PW-1:0]   alloc_idx;
    logic [NNEI-1:0] cred_ok, elig, push_q, pop_q;

    assign wr_ready = !fl_empty;
    assign push     = wr_valid && wr_ready && (int'(wr_hop) < NNEI);
    assign pop      = (state == ST_SEND);

    voq_freelist #(.SLOTS(SLOTS), .PW(PW)) u_free (
        .clk(clk), .rst_n(rst_n),
        .alloc(push), .alloc_idx(alloc_idx),
        .rel_en(pop), .rel_idx(qhead[sel]),
        .empty(fl_empty)
    );

    for (genvar g = 0; g < NNEI; g++) begin : g_nei
        assign push_q[g] = push && (int'(wr_hop) == g);
        assign pop_q[g]  = pop && (int'(sel) == g);
        assign elig[g]   = (qcnt[g] != '0) && cred_ok[g];
        voq_credit #(.NCRED(NCRED), .CW(CW)) u_cred (
            .clk(clk), .rst_n(rst_n),
            .consume(pop_q[g]), .give(cred_ret[g]),
            .has_credit(cred_ok[g])
        );
    end

    voq_rr_pick #(.NNEI(NNEI), .HW(HW)) u_rr (
        .elig(elig), .start(rr), .any(any_elig), .pick(pick)
    );

    // payload and link storage, no reset needed
    always_ff @(posedge clk) begin
        if (push) begin
            mem[alloc_idx] <= wr_data;
            if (qcnt[wr_hop] != '0) nxt[qtail[wr_hop]] <= alloc_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int q = 0; q < NNEI; q++) begin
                qhead[q] <= '0;
                qtail[q] <= '0;
                qcnt[q]  <= '0;
            end
        end else begin
            for (int q = 0; q < NNEI; q++) begin
                if (push_q[q]) begin
                    qtail[q] <= alloc_idx;
                    if (qcnt[q] == '0 || (qcnt[q] == QW'(1) && pop_q[q]))
                        qhead[q] <= alloc_idx;
                    else if (pop_q[q])
                        qhead[q] <= nxt[qhead[q]];
                end else if (pop_q[q]) begin
                    qhead[q] <= nxt[qhead[q]];
                end
                if (push_q[q] && !pop_q[q])      qcnt[q] <= qcnt[q] + 1'b1;
                else if (pop_q[q] && !push_q[q]) qcnt[q] <= qcnt[q] - 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (any_elig) state_nx = ST_REQ;
            ST_REQ:  if (ch_gnt)   state_nx = ST_SEND;
            ST_SEND: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel <= '0;
            rr  <= '0;
        end else begin
            if (state == ST_IDLE && any_elig) sel <= pick;
            if (state == ST_SEND) rr <= (int'(sel) == NNEI - 1) ? '0 : sel + 1'b1;
        end
    end

    // outputs
    always_comb begin
        ch_req   = (state == ST_REQ);
        ch_hop   = sel;
        rd_valid = (state == ST_SEND);
        rd_hop   = sel;
        rd_data  = mem[qhead[sel]];
    end
endmodule

// File: rtl/voq_credit_buf_chk.sv
module voq_credit_buf_chk #(
    parameter int NNEI  = 3,
    parameter int NCRED = 2,
    parameter int HW    = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_valid,
    input logic            wr_ready,
    input logic [HW-1:0]   wr_hop,
    input logic [NNEI-1:0] cred_ret,
    input logic            ch_req,
    input logic [HW-1:0]   ch_hop,
    input logic            ch_gnt,
    input logic            rd_valid,
    input logic [HW-1:0]   rd_hop
);
    localparam int SLOTS = (2 * NNEI - 1) * NCRED;

    int outs [NNEI];
    int occ;
    logic acc;

    assign acc = wr_valid && wr_ready && (int'(wr_hop) < NNEI);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int n = 0; n < NNEI; n++) outs[n] <= 0;
            occ <= 0;
        end else begin
            for (int n = 0; n < NNEI; n++) begin
                if (rd_valid && int'(rd_hop) == n) begin
                    if (!cred_ret[n]) outs[n] <= outs[n] + 1;
                end else if (cred_ret[n] && outs[n] != 0) begin
                    outs[n] <= outs[n] - 1;
                end
            end
            occ <= occ + (acc ? 1 : 0) - (rd_valid ? 1 : 0);
        end
    end

    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_req && !ch_gnt) |=> (ch_req && $stable(ch_hop)));

    p_gnt_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_req && ch_gnt) |=> rd_valid);

    p_read_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_req_has_credit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ch_req |-> (outs[ch_hop] < NCRED));

    p_ready_occ_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready == (occ != SLOTS));

    for (genvar g = 0; g < NNEI; g++) begin : g_bound
        p_outs_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
            outs[g] <= NCRED);
    end
endmodule

bind voq_credit_buf voq_credit_buf_chk #(.NNEI(NNEI), .NCRED(NCRED), .HW(HW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_hop(wr_hop), .cred_ret(cred_ret), .ch_req(ch_req), .ch_hop(ch_hop),
    .ch_gnt(ch_gnt), .rd_valid(rd_valid), .rd_hop(rd_hop)
);

// File: tb/voq_credit_buf_bench.sv
module voq_credit_buf_bench;
    localparam int NNEI  = 3;
    localparam int NCRED = 2;
    localparam int DW    = 16;
    localparam int HW    = 2;
    localparam int SLOTS = (2 * NNEI - 1) * NCRED;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_valid = 1'b0;
    logic            wr_ready;
    logic [HW-1:0]   wr_hop = '0;
    logic [DW-1:0]   wr_data = '0;
    logic [NNEI-1:0] cred_ret = '0;
    logic            ch_req;
    logic [HW-1:0]   ch_hop;
    logic            ch_gnt = 1'b0;
    logic            rd_valid;
    logic [HW-1:0]   rd_hop;
    logic [DW-1:0]   rd_data;

    int n_chk = 0;
    int n_bad = 0;

    logic [DW-1:0] mq [NNEI][$];
    int mcred [NNEI];
    int mrr = 0;
    logic [DW-1:0] tag = 16'h1000;

    always #10 clk = ~clk;

    voq_credit_buf #(.NNEI(NNEI), .NCRED(NCRED), .DW(DW)) u_voq_credit_buf (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_hop(wr_hop), .wr_data(wr_data), .cred_ret(cred_ret),
        .ch_req(ch_req), .ch_hop(ch_hop), .ch_gnt(ch_gnt),
        .rd_valid(rd_valid), .rd_hop(rd_hop), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put(input int hop);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_hop   = HW'(hop);
        wr_data  = tag;
        if (wr_ready) mq[hop].push_back(tag);
        tag = tag + 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic give_credit(input int hop);
        @(negedge clk);
        cred_ret[hop] = 1'b1;
        if (mcred[hop] < NCRED) mcred[hop]++;
        @(negedge clk);
        cred_ret = '0;
    endtask

    function automatic int model_pick();
        for (int k = 0; k < NNEI; k++) begin
            int h;
            h = (mrr + k) % NNEI;
            if (mq[h].size() != 0 && mcred[h] > 0) return h;
        end
        return -1;
    endfunction

    task automatic take(input bit ret);
        int exp_h;
        int waited;
        logic [DW-1:0] exp_d;
        exp_h = model_pick();
        waited = 0;
        @(negedge clk);
        while (!ch_req && waited < 40) begin
            @(negedge clk);
            waited++;
        end
        check(ch_req == 1'b1, "R6 request raised", int'(ch_req), 1);
        check(int'(ch_hop) == exp_h, "R5 round-robin pick", int'(ch_hop), exp_h);
        ch_gnt = 1'b1;
        @(negedge clk);
        ch_gnt = 1'b0;
        check(rd_valid == 1'b1, "R6 read after grant", int'(rd_valid), 1);
        check(int'(rd_hop) == exp_h, "R2 read hop", int'(rd_hop), exp_h);
        if (exp_h >= 0 && mq[exp_h].size() != 0) begin
            exp_d = mq[exp_h].pop_front();
            check(rd_data == exp_d, "R2 data and order", int'(rd_data), int'(exp_d));
            mcred[exp_h]--;
            mrr = (exp_h + 1) % NNEI;
            if (ret) begin
                cred_ret[exp_h] = 1'b1;
                mcred[exp_h]++;
            end
        end
        @(negedge clk);
        cred_ret = '0;
        check(rd_valid == 1'b0, "R6 single-cycle read", int'(rd_valid), 0);
    endtask

    task automatic no_req(input string req, input int cycles);
        bit seen;
        seen = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (ch_req) seen = 1'b1;
        end
        check(!seen, req, int'(seen), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(wr_ready == 1'b1, "R1 ready after reset", int'(wr_ready), 1);
        check(ch_req == 1'b0, "R1 no request after reset", int'(ch_req), 0);
        check(rd_valid == 1'b0, "R1 no read after reset", int'(rd_valid), 0);
    endtask

    task automatic t_single();
        put(1);
        take(1'b1);
    endtask

    task automatic t_order();
        put(2); put(0); put(0);
        repeat (3) take(1'b1);
    endtask

    task automatic t_rr();
        put(1); put(2); put(0); put(1); put(2); put(0);
        repeat (6) take(1'b1);
    endtask

    task automatic t_credit();
        put(0); put(0); put(0);
        take(1'b0);
        take(1'b0);
        no_req("R3 blocked at zero credits", 10);
        give_credit(0);
        take(1'b1);
        give_credit(0);
    endtask

    task automatic t_saturate();
        give_credit(2); give_credit(2); give_credit(2);
        put(2); put(2); put(2);
        take(1'b0);
        take(1'b0);
        no_req("R4 extra returns ignored", 10);
        give_credit(2);
        take(1'b1);
        give_credit(2);
    endtask

    task automatic t_full();
        put(1); put(1);
        take(1'b0);
        take(1'b0);
        repeat (SLOTS) put(1);
        @(negedge clk);
        check(wr_ready == 1'b0, "R7 not ready when pool full", int'(wr_ready), 0);
        put(1);
        give_credit(1);
        give_credit(1);
        repeat (SLOTS) take(1'b1);
        no_req("R7 dropped write never emitted", 10);
        check(wr_ready == 1'b1, "R7 ready after drain", int'(wr_ready), 1);
    endtask

    task automatic t_write_during_req();
        int waited;
        put(2);
        waited = 0;
        while (!ch_req && waited < 20) begin
            @(negedge clk);
            waited++;
        end
        check(ch_req == 1'b1, "R8 request pending", int'(ch_req), 1);
        check(wr_ready == 1'b1, "R8 ready while requesting", int'(wr_ready), 1);
        put(0);
        take(1'b1);
        take(1'b1);
    endtask

    initial begin
        for (int i = 0; i < NNEI; i++) mcred[i] = NCRED;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_order();
        t_rr();
        t_credit();
        t_saturate();
        t_full();
        t_write_during_req();
        repeat (5) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule